// File: doc/BRIEF.md
# Byte ALU with Status-Flag Write Mask

This block is the arithmetic and logic datapath of a small register-to-register machine core. Each cycle it takes a destination operand, a source operand or an immediate, a 4-bit operation code and the current status flags. It returns the 8-bit result, the next value of each of six status flags, and a per-flag write enable. The enable tells the surrounding status register exactly which flags the operation owns. Every flag outside an operation's mask comes back unchanged, so the caller can load `flags_o` into the status register every cycle.

The word-immediate add and subtract act on a 16-bit register pair and take two consecutive cycles. In the first cycle the caller presents the low byte. The block returns the low result, writes no flags and keeps the carry or borrow and a low-byte-zero indication internally. In the second cycle `word_hi_o` is high and the caller presents the high byte. The block then returns the high result together with flags that describe the whole 16-bit value. The operation code is not looked at during that second cycle. Register file, decode and multiplication sit outside this block.

Top module: `alu8_status`

## Requirements
- R1: Flag vector bit positions are C=0, Z=1, N=2, V=3, S=4, H=5. For every flag whose bit in `flag_we_o` is 0, `flags_o` equals `flags_i`. Opcodes are: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 OR, 6 XOR, 7 COM, 8 NEG, 9 INC, 10 DEC, 11 CLR, 12 SER, 13 CBR, 14 WADD, 15 WSUB. When `src_imm_i` is 1, `imm_i` replaces `op_b_i` as the second operand of ADD, ADC, SUB, SBC, AND, OR, XOR and CBR.
- R2: ADD and ADC return the 8-bit sum and write all six flags. C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow. ADC adds the incoming C.
- R3: SUB and SBC return A minus B, and NEG returns 0x00 minus A. All three write all six flags. C is the borrow out of bit 7, H is the borrow into bit 4 from bit 3, and V is signed overflow. SBC also subtracts the incoming C.
- R4: For ADC and SBC the new Z is 1 only if the result is zero and the incoming Z is 1.
- R5: AND, OR, XOR and CBR write exactly Z, N, V and S, and always clear V. CBR returns A AND NOT B, so OR with the immediate sets bits and CBR clears them.
- R6: COM returns NOT A. It writes Z, C, N, V and S, with C set to 1 and V cleared.
- R7: INC and DEC return A+1 and A-1 and write exactly Z, N, V and S. V is 1 only for 0x7F→0x80 on INC and for 0x80→0x7F on DEC, and C is kept.
- R8: CLR returns 0x00 with Z=1 and N=V=S=0, writing Z, N, V and S. SER returns 0xFF and writes no flag.
- R9: Whenever S is written, it equals the written N XOR the written V.
- R10: In the first cycle of WADD or WSUB, `res_o` is the low byte plus or minus `imm_i[5:0]` zero-extended, with bits 7:6 of `imm_i` ignored. No flag is written, `word_hi_o` is 0, and it becomes 1 in the following cycle.
- R11: While `word_hi_o` is 1, `res_o` is the high byte plus the stored carry, or minus the stored borrow, regardless of `op_i`. Z, C, N, V and S are written for the 16-bit result: Z is 1 only if both bytes are zero, and V is signed overflow of the word. H is kept, and `word_hi_o` returns to 0 in the next cycle.
- R12: Asserting `rst_n` low clears `word_hi_o` at once, including in the middle of a word operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| op_i | input | 4 | Operation code (see R1) |
| src_imm_i | input | 1 | Select `imm_i` instead of `op_b_i` as second operand |
| op_a_i | input | 8 | Destination operand (low then high byte for word operations) |
| op_b_i | input | 8 | Source register operand |
| imm_i | input | 8 | Immediate; bits 5:0 used by word operations |
| flags_i | input | 6 | Current status flags |
| res_o | output | 8 | Result byte |
| flags_o | output | 6 | Next status flags |
| flag_we_o | output | 6 | Per-flag write enable |
| word_hi_o | output | 1 | High-byte cycle of a word operation in progress |

## Verification
The bench aims at the flag edges where an off-by-one in carry or borrow shows. Examples are 0x80+0x80, half-carry from 0x0F+0x01, NEG of 0x80 and 0x00, and INC/DEC across the signed boundary; getting the borrow polarity wrong would invert C and H on every subtraction. It runs SBC on equal operands with the incoming Z both set and cleared, which a design without the Z chain would report as zero in both cases. It runs word operations whose low byte is zero but whose high byte is not, and the reverse. Word operations also run with garbage in `imm_i[7:6]` and a random opcode in the second cycle, so that a design that ignores the stored carry, extends the immediate wrongly or decodes the opcode again would return a wrong high byte or a wrong Z. A reset during the high cycle checks that the sequencer state is dropped at once.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int NFLAG = 6;
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_COM  = 4'd7,
    OP_NEG  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_CLR  = 4'd11,
    OP_SER  = 4'd12,
    OP_CBR  = 4'd13,
    OP_WADD = 4'd14,
    OP_WSUB = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_NOT} logic_sel_e;
  typedef enum logic [1:0] {RK_SUM, RK_LOGIC, RK_ONES} res_kind_e;

  // write masks, bit order {H,S,V,N,Z,C}
  localparam logic [NFLAG-1:0] MASK_ALL   = 6'h3F;
  localparam logic [NFLAG-1:0] MASK_ZNVS  = 6'h1E;
  localparam logic [NFLAG-1:0] MASK_CZNVS = 6'h1F;
  localparam logic [NFLAG-1:0] MASK_NONE  = 6'h00;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co,
  output logic         ch,
  output logic         ov
);
  localparam int HW = W / 2;
  localparam int UW = W - HW;

  logic [HW:0] lo_sum;
  logic [UW:0] hi_sum;

  // split at the half-byte so the half carry is a real node, not a recompute
  assign lo_sum = {1'b0, x[HW-1:0]} + {1'b0, y[HW-1:0]} + {{HW{1'b0}}, ci};
  assign hi_sum = {1'b0, x[W-1:HW]} + {1'b0, y[W-1:HW]} + {{UW{1'b0}}, lo_sum[HW]};

  assign s  = {hi_sum[UW-1:0], lo_sum[HW-1:0]};
  assign co = hi_sum[UW];
  assign ch = lo_sum[HW];
  assign ov = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic_sel_e   sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r
);
  always_comb begin
    unique case (sel)
      LG_AND:  r = a & b;
      LG_OR:   r = a | b;
      LG_XOR:  r = a ^ b;
      LG_NOT:  r = ~a;
      default: r = a & b;
    endcase
  end
endmodule

// File: rtl/alu8_word_seq.sv
module alu8_word_seq (
  input  logic clk,
  input  logic rst_q_n,
  input  logic start_i,
  input  logic sub_i,
  input  logic carry_i,
  input  logic zero_i,
  output logic hi_o,
  output logic sub_o,
  output logic carry_o,
  output logic zero_o
);
  logic hi_q, hi_d, sub_q, sub_d, c_q, c_d, z_q, z_d, en;

  always_comb begin
    en    = start_i | hi_q;
    hi_d  = start_i;
    sub_d = sub_i;
    c_d   = carry_i;
    z_d   = zero_i;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      hi_q  <= 1'b0;
      sub_q <= 1'b0;
      c_q   <= 1'b0;
      z_q   <= 1'b0;
    end else if (en) begin
      hi_q  <= hi_d;
      sub_q <= sub_d;
      c_q   <= c_d;
      z_q   <= z_d;
    end
  end

  assign hi_o    = hi_q;
  assign sub_o   = sub_q;
  assign carry_o = c_q;
  assign zero_o  = z_q;
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
#(
  parameter int W    = 8,
  parameter int WIMM = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           op_i,
  input  logic                 src_imm_i,
  input  logic [W-1:0]         op_a_i,
  input  logic [W-1:0]         op_b_i,
  input  logic [W-1:0]         imm_i,
  input  logic [NFLAG-1:0]     flags_i,
  output logic [W-1:0]         res_o,
  output logic [NFLAG-1:0]     flags_o,
  output logic [NFLAG-1:0]     flag_we_o,
  output logic                 word_hi_o
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam int PADW = W - WIMM;

  alu_op_e      op;
  logic         rst_meta_n, rst_q_n;
  logic [W-1:0] opnd_b, add_y, y_eff, sum, lg_b, lg_r, res;
  logic [W-1:0] add_x;
  logic         add_ci, ci_eff, co, ch, ov;
  logic         use_sub, use_arith, chain_z, z_prev, c_fix, h_fix;
  logic         word_start, w_sub_q, w_c_q, w_z_q;
  logic [NFLAG-1:0] we, nf;
  logic_sel_e   lg_sel;
  res_kind_e    rkind;
  logic         n_bit, v_bit;

  assign op = alu_op_e'(op_i);

  // reset: asserts asynchronously, leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  assign opnd_b     = src_imm_i ? imm_i : op_b_i;
  assign word_start = !word_hi_o && ((op == OP_WADD) || (op == OP_WSUB));

  // operation steering
  always_comb begin
    add_x     = op_a_i;
    add_y     = opnd_b;
    add_ci    = 1'b0;
    use_sub   = 1'b0;
    use_arith = 1'b1;
    chain_z   = 1'b0;
    lg_sel    = LG_AND;
    lg_b      = opnd_b;
    rkind     = RK_SUM;
    we        = MASK_NONE;
    if (word_hi_o) begin
      add_y   = '0;
      add_ci  = w_c_q;
      use_sub = w_sub_q;
      chain_z = 1'b1;
      we      = MASK_CZNVS;
    end else begin
      unique case (op)
        OP_ADD: we = MASK_ALL;
        OP_ADC: begin add_ci = flags_i[FL_C]; chain_z = 1'b1; we = MASK_ALL; end
        OP_SUB: begin use_sub = 1'b1; we = MASK_ALL; end
        OP_SBC: begin
          use_sub = 1'b1; add_ci = flags_i[FL_C]; chain_z = 1'b1; we = MASK_ALL;
        end
        OP_NEG: begin add_x = '0; add_y = op_a_i; use_sub = 1'b1; we = MASK_ALL; end
        OP_INC: begin add_y = ONE; we = MASK_ZNVS; end
        OP_DEC: begin add_y = ONE; use_sub = 1'b1; we = MASK_ZNVS; end
        OP_AND: begin use_arith = 1'b0; rkind = RK_LOGIC; we = MASK_ZNVS; end
        OP_OR:  begin
          use_arith = 1'b0; rkind = RK_LOGIC; lg_sel = LG_OR; we = MASK_ZNVS;
        end
        OP_XOR: begin
          use_arith = 1'b0; rkind = RK_LOGIC; lg_sel = LG_XOR; we = MASK_ZNVS;
        end
        OP_CBR: begin
          use_arith = 1'b0; rkind = RK_LOGIC; lg_b = ~opnd_b; we = MASK_ZNVS;
        end
        OP_COM: begin
          use_arith = 1'b0; rkind = RK_LOGIC; lg_sel = LG_NOT; we = MASK_CZNVS;
        end
        OP_CLR: begin
          use_arith = 1'b0; rkind = RK_LOGIC; lg_sel = LG_XOR; lg_b = op_a_i;
          we = MASK_ZNVS;
        end
        OP_SER: begin use_arith = 1'b0; rkind = RK_ONES; end
        OP_WADD, OP_WSUB: begin
          add_y   = {{PADW{1'b0}}, imm_i[WIMM-1:0]};
          use_sub = (op == OP_WSUB);
        end
        default: we = MASK_NONE;
      endcase
    end
  end

  // subtract = add of inverted operand, borrow-in inverted to carry-in
  assign y_eff  = use_sub ? ~add_y : add_y;
  assign ci_eff = use_sub ? ~add_ci : add_ci;

  alu8_adder #(.W(W)) u_add (
    .x(add_x), .y(y_eff), .ci(ci_eff), .s(sum), .co(co), .ch(ch), .ov(ov)
  );

  alu8_logic #(.W(W)) u_log (
    .sel(lg_sel), .a(op_a_i), .b(lg_b), .r(lg_r)
  );

  assign c_fix = use_sub ? ~co : co;
  assign h_fix = use_sub ? ~ch : ch;

  always_comb begin
    unique case (rkind)
      RK_SUM:   res = sum;
      RK_LOGIC: res = lg_r;
      RK_ONES:  res = '1;
      default:  res = sum;
    endcase
  end

  alu8_word_seq u_seq (
    .clk(clk), .rst_q_n(rst_q_n), .start_i(word_start), .sub_i(use_sub),
    .carry_i(c_fix), .zero_i(sum == '0),
    .hi_o(word_hi_o), .sub_o(w_sub_q), .carry_o(w_c_q), .zero_o(w_z_q)
  );

  assign z_prev = word_hi_o ? w_z_q : flags_i[FL_Z];
  assign n_bit  = res[W-1];
  assign v_bit  = use_arith & ov;

  always_comb begin
    nf        = '0;
    nf[FL_C]  = use_arith ? c_fix : 1'b1;
    nf[FL_Z]  = (res == '0) & (chain_z ? z_prev : 1'b1);
    nf[FL_N]  = n_bit;
    nf[FL_V]  = v_bit;
    nf[FL_S]  = n_bit ^ v_bit;
    nf[FL_H]  = h_fix;
  end

  assign res_o     = res;
  assign flag_we_o = we;
  assign flags_o   = (nf & we) | (flags_i & ~we);
endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic [3:0]       op_i,
  input logic             word_hi_o,
  input logic [NFLAG-1:0] flags_i,
  input logic [NFLAG-1:0] flags_o,
  input logic [NFLAG-1:0] flag_we_o,
  input logic [W-1:0]     res_o
);
  logic is_word, is_logic;
  assign is_word  = (op_i == OP_WADD) || (op_i == OP_WSUB);
  assign is_logic = op_i inside {OP_AND, OP_OR, OP_XOR, OP_CBR};

  a_r1_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((flags_o ^ flags_i) & ~flag_we_o) == '0);

  a_r9_s_is_n_xor_v: assert property (@(posedge clk) disable iff (!rst_q_n)
    flag_we_o[FL_S] |-> (flags_o[FL_S] == (flags_o[FL_N] ^ flags_o[FL_V])));

  a_r10_low_silent: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!word_hi_o && is_word) |-> (flag_we_o == '0));

  a_r10_enter_high: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!word_hi_o && is_word) |=> word_hi_o);

  a_r11_leave_high: assert property (@(posedge clk) disable iff (!rst_q_n)
    word_hi_o |=> !word_hi_o);

  a_r11_keep_h: assert property (@(posedge clk) disable iff (!rst_q_n)
    word_hi_o |-> (!flag_we_o[FL_H] && flag_we_o[FL_C]));

  a_r8_ser_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!word_hi_o && op_i == OP_SER) |-> (flag_we_o == '0 && res_o == '1));

  a_r5_logic_clears_v: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!word_hi_o && is_logic) |-> (flag_we_o == MASK_ZNVS && !flags_o[FL_V]));

  a_r6_com_sets_c: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!word_hi_o && op_i == OP_COM) |-> (flag_we_o[FL_C] && flags_o[FL_C]));
endmodule

bind alu8_status alu8_status_chk #(.W(W)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .op_i(op_i), .word_hi_o(word_hi_o),
  .flags_i(flags_i), .flags_o(flags_o), .flag_we_o(flag_we_o), .res_o(res_o)
);

// File: tb/alu8_status_tb_top.sv
module alu8_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SEED = 32'h5A17;

  logic       clk, rst_n, src_imm_i, word_hi_o;
  logic [3:0] op_i;
  logic [7:0] op_a_i, op_b_i, imm_i, res_o;
  logic [5:0] flags_i, flags_o, flag_we_o;
  int n_chk = 0;
  int n_fail = 0;

  alu8_status dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .src_imm_i(src_imm_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .imm_i(imm_i), .flags_i(flags_i),
    .res_o(res_o), .flags_o(flags_o), .flag_we_o(flag_we_o), .word_hi_o(word_hi_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // returns {res, we, flags_out}
  function automatic logic [19:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [5:0] fin);
    int x, y, ci, r, sx, sy, sr;
    logic [7:0] res;
    logic [5:0] we, nf;
    logic c, z, n, v, h, zc;
    c = 1'b0; v = 1'b0; h = 1'b0; zc = 1'b0; we = 6'h00; res = 8'h00;
    case (op)
      4'd0, 4'd1: begin
        ci = (op == 4'd1) ? int'(fin[0]) : 0;
        r = int'(a) + int'(b) + ci; res = 8'(r); c = (r > 255);
        h = ((int'(a) % 16) + (int'(b) % 16) + ci) > 15;
        sx = $signed(a); sy = $signed(b); sr = sx + sy + ci;
        v = (sr > 127) || (sr < -128); we = 6'h3F; zc = (op == 4'd1);
      end
      4'd2, 4'd3, 4'd8: begin
        x = (op == 4'd8) ? 0 : int'(a); y = (op == 4'd8) ? int'(a) : int'(b);
        ci = (op == 4'd3) ? int'(fin[0]) : 0;
        r = x - y - ci; res = 8'(r); c = (r < 0);
        h = (x % 16) < ((y % 16) + ci);
        sx = (op == 4'd8) ? 0 : int'($signed(a));
        sy = (op == 4'd8) ? int'($signed(a)) : int'($signed(b));
        sr = sx - sy - ci; v = (sr > 127) || (sr < -128);
        we = 6'h3F; zc = (op == 4'd3);
      end
      4'd4:  begin res = a & b;  we = 6'h1E; end
      4'd5:  begin res = a | b;  we = 6'h1E; end
      4'd6:  begin res = a ^ b;  we = 6'h1E; end
      4'd13: begin res = a & ~b; we = 6'h1E; end
      4'd7:  begin res = ~a; c = 1'b1; we = 6'h1F; end
      4'd9:  begin res = a + 8'd1; v = (a == 8'h7F); we = 6'h1E; end
      4'd10: begin res = a - 8'd1; v = (a == 8'h80); we = 6'h1E; end
      4'd11: begin res = 8'h00; we = 6'h1E; end
      default: begin res = 8'hFF; we = 6'h00; end
    endcase
    z = (res == 8'h00) && (!zc || fin[1]);
    n = res[7];
    nf = {h, n ^ v, v, n, z, c};
    return {res, we, (nf & we) | (fin & ~we)};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0:  return "R2 R1 R9";
      4'd1:  return "R2 R4 R9";
      4'd2, 4'd8: return "R3 R1 R9";
      4'd3:  return "R3 R4 R9";
      4'd7:  return "R6 R1 R9";
      4'd9, 4'd10: return "R7 R1 R9";
      4'd11, 4'd12: return "R8 R1";
      default: return "R5 R1 R9";
    endcase
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] k, input logic src, input logic [5:0] fin,
                        input string tag);
    logic [19:0] exp;
    @(negedge clk);
    op_i = op; op_a_i = a; op_b_i = b; imm_i = k; src_imm_i = src; flags_i = fin;
    #(CLK_PERIOD/4);
    exp = model(op, a, src ? k : b, fin);
    chk({res_o, flag_we_o, flags_o} == exp && !word_hi_o, tag,
        {11'd0, word_hi_o, res_o, flag_we_o, flags_o}, {12'd0, exp});
  endtask

  task automatic run_lit(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [5:0] fin, input logic [7:0] er, input logic [5:0] ef,
                         input string tag);
    @(negedge clk);
    op_i = op; op_a_i = a; op_b_i = b; imm_i = 8'h00; src_imm_i = 1'b0; flags_i = fin;
    #(CLK_PERIOD/4);
    chk(res_o == er && flags_o == ef, tag, {18'd0, res_o, flags_o}, {18'd0, er, ef});
  endtask

  task automatic run_word(input bit sub, input logic [15:0] w, input logic [5:0] k,
                          input logic [1:0] junk_hi_imm, input logic [3:0] junk_op,
                          input logic [5:0] fin);
    int r;
    logic [15:0] r16;
    logic c, z, n, v;
    logic [5:0] ef;
    r   = sub ? int'(w) - int'(k) : int'(w) + int'(k);
    r16 = 16'(r);
    c   = sub ? (int'(w) < int'(k)) : (r > 65535);
    z   = (r16 == 16'h0000);
    n   = r16[15];
    v   = sub ? (w[15] & ~r16[15]) : (~w[15] & r16[15]);
    ef  = ({1'b0, n ^ v, v, n, z, c} & 6'h1F) | (fin & 6'h20);
    @(negedge clk);
    op_i = sub ? 4'd15 : 4'd14; op_a_i = w[7:0]; op_b_i = 8'hA5;
    imm_i = {junk_hi_imm, k}; src_imm_i = 1'b1; flags_i = fin;
    #(CLK_PERIOD/4);
    chk(res_o == r16[7:0] && flag_we_o == 6'h00 && flags_o == fin && !word_hi_o,
        "R10 low cycle", {11'd0, word_hi_o, res_o, flag_we_o, flags_o},
        {12'd0, r16[7:0], 6'h00, fin});
    @(negedge clk);
    op_i = junk_op; op_a_i = w[15:8]; src_imm_i = 1'b0;
    #(CLK_PERIOD/4);
    chk(word_hi_o && res_o == r16[15:8] && flag_we_o == 6'h1F && flags_o == ef,
        "R11 high cycle", {11'd0, word_hi_o, res_o, flag_we_o, flags_o},
        {12'h001, r16[15:8], 6'h1F, ef});
    @(negedge clk);
    op_i = 4'd12;
    #(CLK_PERIOD/4);
    chk(!word_hi_o, "R11 back to idle", {31'd0, word_hi_o}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(SEED));
    rst_n = 1'b0; op_i = 4'd12; src_imm_i = 1'b0;
    op_a_i = '0; op_b_i = '0; imm_i = '0; flags_i = '0;
    repeat (3) @(negedge clk);
    chk(!word_hi_o, "R12 reset state", {31'd0, word_hi_o}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed arithmetic corners
    run_lit(4'd0, 8'h80, 8'h80, 6'h00, 8'h00, 6'h1B, "R2 0x80+0x80");
    run_op(4'd0, 8'h0F, 8'h01, 8'h00, 1'b0, 6'h00, "R2 half carry");
    run_op(4'd1, 8'hFF, 8'h00, 8'h00, 1'b0, 6'h03, "R2 R4 adc carry in");
    run_lit(4'd3, 8'h05, 8'h05, 6'h00, 8'h00, 6'h00, "R4 sbc Z chain prev0");
    run_lit(4'd3, 8'h05, 8'h05, 6'h02, 8'h00, 6'h02, "R4 sbc Z chain prev1");
    run_op(4'd3, 8'h05, 8'h04, 8'h00, 1'b0, 6'h01, "R3 R4 sbc borrow in");
    run_op(4'd2, 8'h10, 8'h01, 8'h00, 1'b0, 6'h00, "R3 half borrow");
    run_op(4'd2, 8'h00, 8'h01, 8'h00, 1'b0, 6'h00, "R3 borrow out");
    run_op(4'd8, 8'h80, 8'h00, 8'h00, 1'b0, 6'h00, "R3 neg 0x80");
    run_op(4'd8, 8'h00, 8'h00, 8'h00, 1'b0, 6'h3F, "R3 neg zero");
    run_op(4'd9, 8'h7F, 8'h00, 8'h00, 1'b0, 6'h21, "R7 inc overflow");
    run_op(4'd10, 8'h80, 8'h00, 8'h00, 1'b0, 6'h01, "R7 dec overflow");
    run_op(4'd10, 8'h00, 8'h00, 8'h00, 1'b0, 6'h20, "R7 dec keeps C");
    run_op(4'd7, 8'h5A, 8'h00, 8'h00, 1'b0, 6'h08, "R6 com");
    run_op(4'd11, 8'hC3, 8'h00, 8'h00, 1'b0, 6'h2D, "R8 clr");
    run_lit(4'd12, 8'h00, 8'h00, 6'h15, 8'hFF, 6'h15, "R8 ser no flags");
    run_op(4'd5, 8'h81, 8'hFF, 8'h18, 1'b1, 6'h08, "R5 set bits imm");
    run_op(4'd13, 8'hFF, 8'h00, 8'hF0, 1'b1, 6'h08, "R5 clear bits imm");
    run_op(4'd6, 8'h3C, 8'h3C, 8'h00, 1'b0, 6'h08, "R5 xor zero");

    // word sequences
    run_word(1'b0, 16'h00FF, 6'd1, 2'b11, 4'd12, 6'h00);
    run_word(1'b0, 16'hFFFF, 6'd1, 2'b10, 4'd0, 6'h20);
    run_word(1'b0, 16'h7FFF, 6'd1, 2'b01, 4'd3, 6'h00);
    run_word(1'b0, 16'h0000, 6'd3, 2'b11, 4'd14, 6'h02);
    run_word(1'b1, 16'h0000, 6'd1, 2'b11, 4'd15, 6'h00);
    run_word(1'b1, 16'h8000, 6'd1, 2'b00, 4'd7, 6'h3F);
    run_word(1'b1, 16'h0005, 6'd5, 2'b10, 4'd11, 6'h00);
    run_word(1'b1, 16'h0105, 6'd5, 2'b01, 4'd2, 6'h02);

    // random single-cycle ops
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      op = 4'($urandom % 14);
      run_op(op, 8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
             6'($urandom), tag_of(op));
    end

    // random word ops
    for (int i = 0; i < 40; i++) begin
      run_word(1'($urandom), 16'($urandom), 6'($urandom), 2'($urandom),
               4'($urandom), 6'($urandom));
    end

    // reset in the middle of a word operation
    @(negedge clk);
    op_i = 4'd14; op_a_i = 8'h10; imm_i = 8'h01;
    @(posedge clk);
    #1;
    chk(word_hi_o, "R10 entered high before reset", {31'd0, word_hi_o}, 32'd1);
    rst_n = 1'b0;
    #1;
    chk(!word_hi_o, "R12 async clear mid word", {31'd0, word_hi_o}, 32'd0);
    op_i = 4'd12;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_op(4'd0, 8'h01, 8'h02, 8'h00, 1'b0, 6'h00, "R12 R2 after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule